// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block sits between a synchronous host and a 256K x 1 dynamic memory with a multiplexed address bus. The host issues single-bit reads and writes through a request/ready handshake with an 18-bit word address. Each request becomes one strobe cycle. The row half of the address goes out first and the row strobe falls. The column half follows and the column strobe falls. For a read, the data bit is sampled once both access times have passed and is returned with a one-cycle valid pulse. Writes use early write: the write strobe is low before the column strobe falls, so the memory keeps its output pin high-impedance.

Every delay is a nanosecond figure converted at elaboration into a count of clock cycles by rounding up at the chosen clock period. The block also accepts refresh requests. It runs each one as a row-strobe-only cycle on an internal row counter, and the host is held off while that cycle runs.

Top module: `dram_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `ras_n`, `cas_n` and `we_n` are high, `rd_valid` is low and `host_ready` is high.
- R2: An accepted request drives the row half `host_addr[17:9]` on `dram_a` from the cycle in which `ras_n` falls. It switches to the column half `host_addr[8:0]` RAH = ceil(20 ns / period) cycles later, before `cas_n` falls.
- R3: `cas_n` falls CASD = max(ceil(25 ns / period), RAH + 1) cycles after `ras_n` falls, and is never low while `ras_n` is high.
- R4: For an access, `ras_n` and `cas_n` rise together END cycles after the fall of `ras_n`. END is the largest of the 150 ns row-low minimum, the 150 ns column hold after the row fall, CASD plus the 75 ns column-low minimum, the sample point, and CASD plus the write and data hold times, each rounded up to cycles.
- R5: On a write, `we_n` falls together with `ras_n` (before `cas_n`) and stays low until END, and `dram_d` holds the write bit for that whole time. On a read, `we_n` stays high.
- R6: On a read, `dram_q` is captured SAMP = max(ceil(150 ns / period), CASD + ceil(75 ns / period)) cycles after the fall of `ras_n`. It is presented on `rd_data` together with `rd_valid`, which is high for exactly one cycle. Writes produce no `rd_valid`.
- R7: `host_ready` goes low in the cycle after acceptance. It returns high NEXT - 1 cycles after the fall of `ras_n`, where NEXT = max(END + ceil(100 ns / period), ceil(260 ns / period)). `ras_n` therefore never falls again sooner than NEXT cycles later.
- R8: A one-cycle `rfsh_req` pulse is held pending and then served by a refresh cycle. In that cycle `ras_n` is low for ceil(150 ns / period) cycles, with `dram_a` carrying a 9-bit row counter that starts at 0 after reset and advances by one per refresh, while `cas_n` and `we_n` stay high. The precharge rule of R7 follows.
- R9: While a refresh is pending or running, `host_ready` is low. A request accepted while `host_ready` was high runs first, even if a refresh request arrives in the same cycle. An access in progress always completes before a pending refresh starts.
- R10: The parameter set is rejected at elaboration if END cycles exceed the 10 000 ns row-low maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| host_req | input | 1 | host request, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | word address, row in upper half |
| host_wdata | input | 1 | bit to write |
| host_ready | output | 1 | block can accept a request |
| rd_valid | output | 1 | one-cycle read result strobe |
| rd_data | output | 1 | read result bit |
| rfsh_req | input | 1 | refresh request pulse |
| dram_a | output | 9 | multiplexed row/column address |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas_n | output | 1 | column strobe, active low |
| dram_we_n | output | 1 | write strobe, active low |
| dram_d | output | 1 | data into the memory |
| dram_q | input | 1 | data out of the memory |

## Verification
The per-cycle reference model fixes the expected level of every strobe, the address and the handshake for every cycle. An off-by-one in the phase counter or a wrong state therefore shows up on a pin within one clock of the edge it moves. The bench memory model returns the inverted bit until both access times have passed. A sample point that comes too early turns into a wrong `rd_data` on the pulse cycle. A row counter that skips, or an arbitration order that is wrong, shows as a wrong row on `dram_a` in the first cycle of the refresh, or as a strobe fall in a cycle the model holds idle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REF, ST_PRE} dseq_state_e;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dseq_phase_ctr.sv
module dseq_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != '1)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dseq_refresh_arb.sv
module dseq_refresh_arb #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rfsh_req,
  input  logic          grant,
  output logic          pend_q,
  output logic          pend_d,
  output logic [RW-1:0] row_q
);
  assign pend_d = (pend_q & ~grant) | rfsh_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (grant) row_q <= row_q + 1'b1;
    end
  end
endmodule

// File: rtl/dseq_addr_mux.sv
module dseq_addr_mux #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_row,
  input  logic          ld_col,
  input  logic [MW-1:0] row_in,
  input  logic [MW-1:0] col_in,
  output logic [MW-1:0] a_q
);
  always_ff @(posedge clk) begin
    if (rst)         a_q <= '0;
    else if (ld_row) a_q <= row_in;
    else if (ld_col) a_q <= col_in;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int AW          = 18,
  parameter int CLK_NS      = 20,
  parameter int T_RASMIN_NS = 150,
  parameter int T_RASMAX_NS = 10000,
  parameter int T_PRE_NS    = 100,
  parameter int T_CYC_NS    = 260,
  parameter int T_RCD_NS    = 25,
  parameter int T_RAH_NS    = 20,
  parameter int T_CASW_NS   = 75,
  parameter int T_CSH_NS    = 150,
  parameter int T_RAC_NS    = 150,
  parameter int T_CAC_NS    = 75,
  parameter int T_WCH_NS    = 45,
  parameter int T_DH_NS     = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_wdata,
  output logic             host_ready,
  output logic             rd_valid,
  output logic             rd_data,
  input  logic             rfsh_req,
  output logic [AW/2-1:0]  dram_a,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_d,
  input  logic             dram_q
);
  localparam int MW     = AW / 2;
  localparam int RAH_K  = cdiv(T_RAH_NS, CLK_NS);
  localparam int CASD_K = imax(cdiv(T_RCD_NS, CLK_NS), RAH_K + 1);
  localparam int RASW_K = cdiv(T_RASMIN_NS, CLK_NS);
  localparam int SAMP_K = imax(cdiv(T_RAC_NS, CLK_NS), CASD_K + cdiv(T_CAC_NS, CLK_NS));
  localparam int END_K  = imax(imax(imax(RASW_K, cdiv(T_CSH_NS, CLK_NS)),
                                    imax(CASD_K + cdiv(T_CASW_NS, CLK_NS), SAMP_K)),
                               CASD_K + imax(cdiv(T_WCH_NS, CLK_NS), cdiv(T_DH_NS, CLK_NS)));
  localparam int ENDR_K = RASW_K;
  localparam int PRE_K  = cdiv(T_PRE_NS, CLK_NS);
  localparam int CYC_K  = cdiv(T_CYC_NS, CLK_NS);
  localparam int NXTA_K = imax(END_K + PRE_K, CYC_K);
  localparam int NXTR_K = imax(ENDR_K + PRE_K, CYC_K);
  localparam int CW     = $clog2(imax(NXTA_K, NXTR_K) + 1);

  dseq_state_e      state, state_n;
  logic [CW-1:0]    cnt;
  int               k;
  logic             start_acc, start_ref, kind_ref, is_wr;
  logic             rf_pend_q, rf_pend_d;
  logic [MW-1:0]    rf_row, col_q, row_sel;
  logic             ld_col, ready_d;

  assign k = int'(cnt);

  dseq_phase_ctr #(.W(CW)) u_ctr (
    .clk(clk), .rst(rst), .clr(start_acc | start_ref), .cnt(cnt)
  );

  dseq_refresh_arb #(.RW(MW)) u_arb (
    .clk(clk), .rst(rst), .rfsh_req(rfsh_req), .grant(start_ref),
    .pend_q(rf_pend_q), .pend_d(rf_pend_d), .row_q(rf_row)
  );

  assign row_sel = start_ref ? rf_row : host_addr[AW-1:MW];
  assign ld_col  = (state == ST_ACT) && (k == RAH_K - 1);

  dseq_addr_mux #(.MW(MW)) u_amux (
    .clk(clk), .rst(rst), .ld_row(start_acc | start_ref), .ld_col(ld_col),
    .row_in(row_sel), .col_in(col_q), .a_q(dram_a)
  );

  always_comb begin
    start_acc = (state == ST_IDLE) && host_req && host_ready;
    start_ref = (state == ST_IDLE) && !start_acc && rf_pend_q;
    state_n   = state;
    case (state)
      ST_IDLE: if (start_acc) state_n = ST_ACT;
               else if (start_ref) state_n = ST_REF;
      ST_ACT:  if (k == END_K - 1)  state_n = ST_PRE;
      ST_REF:  if (k == ENDR_K - 1) state_n = ST_PRE;
      default: if (k == (kind_ref ? NXTR_K : NXTA_K) - 2) state_n = ST_IDLE;
    endcase
    ready_d = (state_n == ST_IDLE) && !rf_pend_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_ready <= 1'b1;
      rd_valid   <= 1'b0;
      rd_data    <= 1'b0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_d     <= 1'b0;
      is_wr      <= 1'b0;
      kind_ref   <= 1'b0;
      col_q      <= '0;
    end else begin
      state      <= state_n;
      host_ready <= ready_d;
      rd_valid   <= 1'b0;
      if (start_acc) begin
        dram_ras_n <= 1'b0;
        dram_we_n  <= ~host_we;
        dram_d     <= host_wdata;
        is_wr      <= host_we;
        kind_ref   <= 1'b0;
        col_q      <= host_addr[MW-1:0];
      end
      if (start_ref) begin
        dram_ras_n <= 1'b0;
        kind_ref   <= 1'b1;
      end
      if (state == ST_ACT && k == CASD_K - 1) dram_cas_n <= 1'b0;
      if (state == ST_ACT && k == SAMP_K - 1 && !is_wr) begin
        rd_data  <= dram_q;
        rd_valid <= 1'b1;
      end
      if ((state == ST_ACT && k == END_K - 1) || (state == ST_REF && k == ENDR_K - 1)) begin
        dram_ras_n <= 1'b1;
        dram_cas_n <= 1'b1;
        dram_we_n  <= 1'b1;
      end
    end
  end

  // R10
  initial begin
    ras_max_chk: assert (END_K * CLK_NS <= T_RASMAX_NS)
      else $error("row strobe low time exceeds its maximum");
  end

  // R3
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R4
  ras_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> k >= RASW_K);

  // R5
  we_before_cas_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  // R5
  read_we_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT && !is_wr) |-> dram_we_n);

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (dram_ras_n && dram_cas_n));

  // R8
  ref_nocas_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REF) |-> (dram_cas_n && dram_we_n));
endmodule

// File: tb/test_dram_seq.sv
`timescale 1ns/1ps
module test_dram_seq;
  localparam int RAH = 1, CASD = 2, SAMP = 8, ENDA = 8, ENDR = 8, NXT = 13;

  logic clk = 0, rst = 1;
  logic host_req = 0, host_we = 0, host_wdata = 0, rfsh_req = 0, dram_q = 0;
  logic [17:0] host_addr = '0;
  logic host_ready, rd_valid, rd_data, dram_ras_n, dram_cas_n, dram_we_n, dram_d;
  logic [8:0] dram_a;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_seq i_dram_seq (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rfsh_req(rfsh_req),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_d(dram_d), .dram_q(dram_q)
  );

  // behavioural memory: inverted bit until both access times have passed
  bit mem [int];
  logic pr_ras = 1, pr_cas = 1;
  logic [8:0] m_r = 0, m_c = 0;
  time t_ras = 0, t_cas = 0;
  always @(negedge clk) begin
    if (pr_ras && !dram_ras_n) begin m_r = dram_a; t_ras = $time - 10; end
    if (pr_cas && !dram_cas_n) begin
      m_c = dram_a; t_cas = $time - 10;
      if (!dram_we_n) mem[{m_r, m_c}] = dram_d;
    end
    pr_ras = dram_ras_n; pr_cas = dram_cas_n;
    begin
      bit v;
      v = mem.exists({m_r, m_c}) ? mem[{m_r, m_c}] : 1'b0;
      if (!dram_ras_n && !dram_cas_n && ($time - t_ras) >= 150 && ($time - t_cas) >= 75)
        dram_q <= v;
      else
        dram_q <= ~v;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0d, expected %0d", req, $time, act, exp);
    end
  endtask

  // reference model state
  int  m_busy = 0, m_k = 0;   // 0 idle, 1 access, 2 refresh
  bit  m_pend = 0, m_ready = 1, m_wr = 0, m_wd = 0, m_exp = 0;
  int  m_row = 0, m_col = 0, m_rrow = 0, m_rused = 0;
  bit  shadow [int];
  int  lcg = 12345;

  function automatic int rnd(input int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7fff) % m;
  endfunction

  task automatic check_pins();
    int ras, cas, we;
    ras = 1; cas = 1; we = 1;
    if (m_busy == 1 && m_k < ENDA) begin
      ras = 0; cas = (m_k >= CASD) ? 0 : 1; we = m_wr ? 0 : 1;
      chk("R2 address", dram_a, (m_k < RAH) ? m_row : m_col);
      if (m_wr) chk("R5 data in", dram_d, m_wd);
    end
    if (m_busy == 2 && m_k < ENDR) begin
      ras = 0;
      chk("R8 refresh row", dram_a, m_rused);
    end
    chk("R4/R8 ras_n", dram_ras_n, ras);
    chk("R3 cas_n", dram_cas_n, cas);
    chk("R5 we_n", dram_we_n, we);
    chk("R7/R9 host_ready", host_ready, (m_busy == 0) ? m_ready : 0);
    chk("R6 rd_valid", rd_valid, (m_busy == 1 && m_k == SAMP && !m_wr) ? 1 : 0);
    if (m_busy == 1 && m_k == SAMP && !m_wr) chk("R6 rd_data", rd_data, m_exp);
  endtask

  task automatic step_model();
    bit g_ref, pend_old;
    int a;
    g_ref = 0; pend_old = m_pend;
    if (m_busy == 0) begin
      if (host_req && m_ready) begin
        a = host_addr;
        m_busy = 1; m_k = 0; m_row = a >> 9; m_col = a & 511;
        m_wr = host_we; m_wd = host_wdata;
        if (m_wr) shadow[a] = m_wd;
        m_exp = shadow.exists(a) ? shadow[a] : 1'b0;
      end else if (pend_old) begin
        m_busy = 2; m_k = 0; m_rused = m_rrow; m_rrow = (m_rrow + 1) & 511; g_ref = 1;
      end
    end else begin
      m_k++;
      if (m_k == NXT - 1) m_busy = 0;
    end
    m_pend  = (pend_old && !g_ref) || rfsh_req;
    m_ready = (m_busy == 0) && !m_pend;
  endtask

  task automatic drive(input bit rq, input bit we, input int a, input bit wd, input bit rf);
    host_req = rq; host_we = we; host_addr = 18'(a); host_wdata = wd; rfsh_req = rf;
  endtask

  task automatic cyc(input bit rq, input bit we, input int a, input bit wd, input bit rf);
    @(negedge clk);
    check_pins();
    drive(rq, we, a, wd, rf);
    step_model();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 ras_n", dram_ras_n, 1); chk("R1 cas_n", dram_cas_n, 1);
    chk("R1 we_n", dram_we_n, 1);   chk("R1 rd_valid", rd_valid, 0);
    chk("R1 host_ready", host_ready, 1);
    rst = 0;
    drive(0, 0, 0, 0, 0); step_model();
    // directed: write then read same word (R2 R5 R6)
    cyc(1, 1, (9'h1A5 << 9) | 9'h05A, 1, 0);
    repeat (14) cyc(0, 0, 0, 0, 0);
    cyc(1, 0, (9'h1A5 << 9) | 9'h05A, 0, 0);
    repeat (14) cyc(0, 0, 0, 0, 0);
    // read of never-written word (R6)
    cyc(1, 0, 18'h3FFFF, 0, 0);
    repeat (14) cyc(0, 0, 0, 0, 0);
    // back-to-back held request (R7)
    for (int i = 0; i < 40; i++) cyc(1, i[3], 18'h00203 + i[2:0], i[0], 0);
    // refresh during access, and refresh same cycle as accept (R9)
    cyc(1, 1, 18'h00400, 1, 0);
    cyc(0, 0, 0, 0, 1);
    repeat (30) cyc(1, 0, 18'h00400, 0, 0);
    repeat (20) cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 18'h00001, 0, 1);
    repeat (40) cyc(0, 0, 0, 0, 0);
    // idle refresh bursts (R8)
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 1);
      repeat (15) cyc(1, 0, 0, 0, 0);
    end
    // random traffic over a small address set
    for (int i = 0; i < 4000; i++)
      cyc(rnd(2) == 0, rnd(2) == 1, (rnd(4) << 9) | rnd(4), rnd(2) == 1, rnd(30) == 0);
    repeat (20) cyc(0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule